// File: doc/BRIEF.md
# Three-Dimensional DMA Parameter Sequencer

This block keeps a table of transfer descriptors and turns synchronization events into a stream of array-sized transfer requests. Each descriptor describes a three-dimensional move: a byte count per array, arrays per frame and frames per block. The source and destination each have their own stride between arrays and between frames, and each side can be held at a fixed address instead of incrementing. An event on channel `c` services descriptor `c`. Depending on the descriptor's sync mode, one event produces a single array or a whole frame of arrays. The block then writes the advanced counters and addresses back into the table.

When a descriptor runs out, the sequencer refills it from another descriptor named in its link field, or leaves it empty if there is no link. It can raise a completion pulse and can post a follow-on event to a chained channel, either after every event or only after the last one. Software fills the table through a simple word-write port. Data movement itself happens downstream of the request output.

Top module: `dma3d_seq`

## Requirements
- R1: After reset every descriptor word is zero, so every descriptor is empty, and `tr_valid`, `done_irq` and `err_evt` are low.
- R2: A write stores `cfg_wdata` into word `cfg_word` of descriptor `cfg_set`. The word layout is as follows. Word 0 holds the options: bit 0 frame-per-event mode, bit 1 fixed source, bit 2 fixed destination, bit 3 completion pulse enable, bit 4 chain on completion, bit 5 chain after each non-final event, and bits 15:8 the chain channel. Word 1 is the source address and word 2 the destination address. Word 3 holds the array byte count in 15:0 and the arrays per frame in 31:16. Word 4 holds the frame count in 15:0 and the link in 31:16. Word 5 holds the source array stride in 15:0 and the destination array stride in 31:16. Word 6 holds the source frame stride in 15:0 and the destination frame stride in 31:16. Word 7 holds the arrays-per-frame reload value in 15:0. All strides are signed 16-bit values.
- R3: With bit 0 clear, one event issues exactly one request at the current addresses. If more than one array is left in the frame, each address advances by its array stride and the array count drops by one. After the last array of a frame, each address advances by its frame stride from that array's start, the array count is reloaded from word 7, and the frame count drops by one.
- R4: With bit 0 set, one event issues one request per array of the frame on consecutive cycles, at addresses base + k·(array stride). Afterwards the frame start moves by the frame stride from the previous frame start, and the frame count drops by one.
- R5: A side whose fixed bit is set keeps the same address for every request and every update.
- R6: When the frame count reaches zero and the link is not 0xFFFF, the whole descriptor is replaced by a copy of descriptor `link`.
- R7: When the frame count reaches zero and the link is 0xFFFF, the descriptor is cleared to all zeros.
- R8: A descriptor whose frame count or array count is zero is empty. An event on it pulses `err_evt` for one cycle with `err_chan` set to the channel, and issues no request.
- R9: On the event that brings the frame count to zero, `done_irq` pulses for one cycle with `done_chan` set, if and only if bit 3 is set.
- R10: With bit 4 set, final completion posts an event to the chain channel.
- R11: With bit 5 set, every non-final event posts an event to the chain channel, so one event can drive the whole block.
- R12: Events that arrive while the block is busy are held and not lost. When several channels are waiting, the lowest channel number is served first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Descriptor word write strobe |
| cfg_set | input | 7 | Descriptor index for the write |
| cfg_word | input | 3 | Word index within the descriptor |
| cfg_wdata | input | 32 | Write data |
| evt_valid | input | 1 | Synchronization event strobe |
| evt_chan | input | 6 | Channel of the event |
| tr_valid | output | 1 | Transfer request valid, one array per cycle |
| tr_src | output | 32 | Source address of the array |
| tr_dst | output | 32 | Destination address of the array |
| tr_bytes | output | 16 | Bytes in the array |
| tr_chan | output | 6 | Channel that issued the request |
| done_irq | output | 1 | Completion pulse |
| done_chan | output | 6 | Channel that completed |
| err_evt | output | 1 | Event-on-empty-descriptor pulse |
| err_chan | output | 6 | Channel of the rejected event |

## Verification
The hardest situation to reach from the ports is several waiting channels together with a full descriptor life cycle: a refill through the link, then further events that use the copied contents, then exhaustion to an empty set. The stimulus fires three events on back-to-back cycles while a long frame is still issuing. It also drives a linked descriptor through both of its frames and on into the descriptor it was refilled from, until an event hits the cleared set. A bench-side model of the table predicts every request, pulse and error in order, including events that chained channels post by themselves.

// File: rtl/dma3d_pkg.sv
// Package: shared descriptor types for the 3-D DMA parameter sequencer.
// Assumes eight 32-bit words per descriptor, word 7 in the top bits.
package dma3d_pkg;

    localparam int WORDS_PER_SET = 8;
    localparam logic [15:0] NO_LINK = 16'hFFFF;

    // Raw descriptor storage: element [w] is word w.
    typedef logic [WORDS_PER_SET-1:0][31:0] set_words_t;

    // Field view of a descriptor; bit-identical to set_words_t.
    typedef struct packed {
        logic [15:0] rsvd7;
        logic [15:0] arr_reload;
        logic [15:0] dst_fstride;
        logic [15:0] src_fstride;
        logic [15:0] dst_astride;
        logic [15:0] src_astride;
        logic [15:0] link;
        logic [15:0] frames;
        logic [15:0] arrays;
        logic [15:0] bytes;
        logic [31:0] dst;
        logic [31:0] src;
        logic [15:0] rsvd0_hi;
        logic [7:0]  chain_ch;
        logic [1:0]  rsvd0_lo;
        logic        mid_chain;
        logic        fin_chain;
        logic        irq_en;
        logic        dst_fixed;
        logic        src_fixed;
        logic        frame_sync;
    } pset_t;

endpackage

// File: rtl/dma3d_param_table.sv
// Module: descriptor table held in flops.
// Offers one word-write port for software, one full-descriptor write-back
// port for the sequencer, and two combinational full-descriptor reads
// (selected channel and link target).
// Assumes: when both writers hit the same descriptor in one cycle, the
// sequencer write-back wins and the software word write is dropped.
module dma3d_param_table
    import dma3d_pkg::*;
#(
    parameter int NUM_SETS = 128,
    localparam int SET_W = $clog2(NUM_SETS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [SET_W-1:0] cfg_set,
    input  logic [2:0]       cfg_word,
    input  logic [31:0]      cfg_wdata,
    input  logic             upd_en,
    input  logic [SET_W-1:0] upd_set,
    input  set_words_t       upd_data,
    input  logic [SET_W-1:0] rda_set,
    output set_words_t       rda_data,
    input  logic [SET_W-1:0] rdb_set,
    output set_words_t       rdb_data
);

    set_words_t mem [NUM_SETS];

    // Storage: clear on reset, then apply write-back and software writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_SETS; i++) begin
                mem[i] <= '0;
            end
        end else begin
            if (upd_en) begin
                mem[upd_set] <= upd_data;
            end
            if (cfg_we && !(upd_en && (upd_set == cfg_set))) begin
                mem[cfg_set][cfg_word] <= cfg_wdata;
            end
        end
    end

    // Read ports: full descriptors, no latency.
    always_comb begin
        rda_data = mem[rda_set];
        rdb_data = mem[rdb_set];
    end

endmodule

// File: rtl/dma3d_evt_pend.sv
// Module: per-channel pending event bits with fixed lowest-number priority.
// Assumes a set and a grant-clear of the same bit in one cycle leave it
// set, so an event that arrives as its channel is granted is kept.
module dma3d_evt_pend #(
    parameter int NUM_CHAN = 64,
    localparam int CH_W = $clog2(NUM_CHAN)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            evt_valid,
    input  logic [CH_W-1:0] evt_chan,
    input  logic            chn_valid,
    input  logic [CH_W-1:0] chn_chan,
    input  logic            grant,
    output logic            any,
    output logic [CH_W-1:0] pick
);

    logic [NUM_CHAN-1:0] pend;
    logic [NUM_CHAN-1:0] set_vec;
    logic [NUM_CHAN-1:0] clr_vec;

    // New requests from the event port and from chaining.
    always_comb begin
        set_vec = '0;
        if (evt_valid) set_vec[evt_chan] = 1'b1;
        if (chn_valid) set_vec[chn_chan] = 1'b1;
    end

    // Priority pick: lowest pending channel number.
    always_comb begin
        pick = '0;
        for (int i = NUM_CHAN - 1; i >= 0; i--) begin
            if (pend[i]) pick = CH_W'(i);
        end
        any = |pend;
        clr_vec = '0;
        if (grant) clr_vec[pick] = 1'b1;
    end

    // Pending register update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend <= '0;
        end else begin
            pend <= (pend & ~clr_vec) | set_vec;
        end
    end

endmodule

// File: rtl/dma3d_step.sv
// Module: combinational counter and address update for one serviced event.
// Takes the descriptor as it was when the event was granted and returns
// the advanced descriptor, plus a flag when the frame count hits zero.
// Assumes the descriptor is not empty (frames and arrays non-zero).
module dma3d_step
    import dma3d_pkg::*;
(
    input  pset_t cur,
    output pset_t nxt,
    output logic  is_final
);

    logic [31:0] src_as, dst_as, src_fs, dst_fs;
    logic        unused_fields;

    // Sign-extended strides, forced to zero on fixed sides.
    always_comb begin
        src_as = cur.src_fixed ? 32'd0 : {{16{cur.src_astride[15]}}, cur.src_astride};
        dst_as = cur.dst_fixed ? 32'd0 : {{16{cur.dst_astride[15]}}, cur.dst_astride};
        src_fs = cur.src_fixed ? 32'd0 : {{16{cur.src_fstride[15]}}, cur.src_fstride};
        dst_fs = cur.dst_fixed ? 32'd0 : {{16{cur.dst_fstride[15]}}, cur.dst_fstride};
    end

    // Next descriptor contents for frame-per-event or array-per-event mode.
    always_comb begin
        nxt      = cur;
        is_final = 1'b0;
        if (cur.frame_sync) begin
            nxt.src    = cur.src + src_fs;
            nxt.dst    = cur.dst + dst_fs;
            nxt.frames = cur.frames - 16'd1;
            is_final   = (cur.frames == 16'd1);
        end else if (cur.arrays > 16'd1) begin
            nxt.src    = cur.src + src_as;
            nxt.dst    = cur.dst + dst_as;
            nxt.arrays = cur.arrays - 16'd1;
        end else begin
            nxt.src    = cur.src + src_fs;
            nxt.dst    = cur.dst + dst_fs;
            nxt.arrays = cur.arr_reload;
            nxt.frames = cur.frames - 16'd1;
            is_final   = (cur.frames == 16'd1);
        end
    end

    assign unused_fields = ^{cur.rsvd7, cur.rsvd0_hi, cur.rsvd0_lo, cur.bytes,
                             cur.link, cur.chain_ch, cur.irq_en,
                             cur.fin_chain, cur.mid_chain};

endmodule

// File: rtl/dma3d_seq.sv
// Module: top of the 3-D DMA parameter sequencer.
// Serves one channel at a time: grant (IDLE), emit one array request per
// cycle (ISSUE), write the advanced or relinked descriptor back (WB).
// Channel c always uses descriptor c; assumes NUM_CHAN <= NUM_SETS.
// Assumes software does not rewrite a descriptor while it is being served.
module dma3d_seq
    import dma3d_pkg::*;
#(
    parameter int NUM_SETS = 128,
    parameter int NUM_CHAN = 64,
    localparam int SET_W = $clog2(NUM_SETS),
    localparam int CH_W  = $clog2(NUM_CHAN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [SET_W-1:0] cfg_set,
    input  logic [2:0]       cfg_word,
    input  logic [31:0]      cfg_wdata,
    input  logic             evt_valid,
    input  logic [CH_W-1:0]  evt_chan,
    output logic             tr_valid,
    output logic [31:0]      tr_src,
    output logic [31:0]      tr_dst,
    output logic [15:0]      tr_bytes,
    output logic [CH_W-1:0]  tr_chan,
    output logic             done_irq,
    output logic [CH_W-1:0]  done_chan,
    output logic             err_evt,
    output logic [CH_W-1:0]  err_chan
);

    typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WB} state_t;

    state_t          state;
    pset_t           cur;
    pset_t           nxt;
    logic [CH_W-1:0] cur_chan;
    logic [31:0]     iss_src, iss_dst;
    logic [15:0]     iss_left;
    logic            is_final;

    logic            pend_any, grant;
    logic [CH_W-1:0] pick;
    logic            chn_valid;
    set_words_t      rda_data, rdb_data, upd_data;
    logic            upd_en;
    logic            sel_empty;
    logic            has_link;

    dma3d_param_table #(.NUM_SETS(NUM_SETS)) table_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_set  (cfg_set),
        .cfg_word (cfg_word),
        .cfg_wdata(cfg_wdata),
        .upd_en   (upd_en),
        .upd_set  (SET_W'(cur_chan)),
        .upd_data (upd_data),
        .rda_set  (SET_W'(pick)),
        .rda_data (rda_data),
        .rdb_set  (cur.link[SET_W-1:0]),
        .rdb_data (rdb_data)
    );

    dma3d_evt_pend #(.NUM_CHAN(NUM_CHAN)) pend_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt_valid(evt_valid),
        .evt_chan (evt_chan),
        .chn_valid(chn_valid),
        .chn_chan (cur.chain_ch[CH_W-1:0]),
        .grant    (grant),
        .any      (pend_any),
        .pick     (pick)
    );

    dma3d_step step_i (
        .cur     (cur),
        .nxt     (nxt),
        .is_final(is_final)
    );

    // Grant and empty-descriptor detection for the picked channel.
    always_comb begin
        grant     = (state == S_IDLE) && pend_any;
        sel_empty = (rda_data[4][15:0] == 16'd0) || (rda_data[3][31:16] == 16'd0);
        has_link  = (cur.link != NO_LINK);
    end

    // Write-back selection: advanced set, linked copy, or cleared set.
    always_comb begin
        upd_en = (state == S_WB);
        if (!is_final)     upd_data = set_words_t'(nxt);
        else if (has_link) upd_data = rdb_data;
        else               upd_data = '0;
        chn_valid = (state == S_WB) && (is_final ? cur.fin_chain : cur.mid_chain);
    end

    // Sequencer state, working copy and registered pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= S_IDLE;
            cur       <= '0;
            cur_chan  <= '0;
            iss_src   <= '0;
            iss_dst   <= '0;
            iss_left  <= '0;
            done_irq  <= 1'b0;
            done_chan <= '0;
            err_evt   <= 1'b0;
            err_chan  <= '0;
        end else begin
            done_irq <= 1'b0;
            err_evt  <= 1'b0;
            case (state)
                S_IDLE: begin
                    if (pend_any) begin
                        cur_chan <= pick;
                        cur      <= pset_t'(rda_data);
                        iss_src  <= rda_data[1];
                        iss_dst  <= rda_data[2];
                        iss_left <= rda_data[0][0] ? rda_data[3][31:16] : 16'd1;
                        if (sel_empty) begin
                            err_evt  <= 1'b1;
                            err_chan <= pick;
                        end else begin
                            state <= S_ISSUE;
                        end
                    end
                end
                S_ISSUE: begin
                    if (!cur.src_fixed) iss_src <= iss_src + {{16{cur.src_astride[15]}}, cur.src_astride};
                    if (!cur.dst_fixed) iss_dst <= iss_dst + {{16{cur.dst_astride[15]}}, cur.dst_astride};
                    iss_left <= iss_left - 16'd1;
                    if (iss_left == 16'd1) state <= S_WB;
                end
                S_WB: begin
                    state <= S_IDLE;
                    if (is_final && cur.irq_en) begin
                        done_irq  <= 1'b1;
                        done_chan <= cur_chan;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // Request outputs, driven straight from the issue registers.
    always_comb begin
        tr_valid = (state == S_ISSUE);
        tr_src   = iss_src;
        tr_dst   = iss_dst;
        tr_bytes = cur.bytes;
        tr_chan  = cur_chan;
    end

endmodule

// File: rtl/dma3d_seq_chk.sv
// Checker: temporal properties of the sequencer outputs, bound to dma3d_seq.
// Assumes src_fixed, src_step and frame_sync reflect the descriptor being served.
module dma3d_seq_chk #(
    parameter int CH_W = 6
) (
    input logic            clk,
    input logic            rst_n,
    input logic            tr_valid,
    input logic [31:0]     tr_src,
    input logic [15:0]     tr_bytes,
    input logic [CH_W-1:0] tr_chan,
    input logic            done_irq,
    input logic            err_evt,
    input logic            src_fixed,
    input logic [15:0]     src_step,
    input logic            frame_sync
);

    // R8: a rejected event never coincides with a request.
    a_r8_err_no_request: assert property (@(posedge clk) disable iff (!rst_n)
        err_evt |-> !tr_valid);

    // R9: the completion pulse lasts a single cycle.
    a_r9_irq_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        done_irq |=> !done_irq);

    // R9: completion is signalled outside request cycles.
    a_r9_irq_not_in_burst: assert property (@(posedge clk) disable iff (!rst_n)
        done_irq |-> !tr_valid);

    // R3: array-per-event mode issues exactly one request.
    a_r3_single_array: assert property (@(posedge clk) disable iff (!rst_n)
        (tr_valid && !frame_sync) |=> !tr_valid);

    // R4: back-to-back requests belong to one frame of one channel.
    a_r4_burst_same_chan: assert property (@(posedge clk) disable iff (!rst_n)
        (tr_valid && $past(tr_valid)) |-> (tr_chan == $past(tr_chan) && tr_bytes == $past(tr_bytes)));

    // R4: inside a frame the source advances by its array stride.
    a_r4_array_stride: assert property (@(posedge clk) disable iff (!rst_n)
        (tr_valid && $past(tr_valid) && !src_fixed) |->
            (tr_src == $past(tr_src) + {{16{src_step[15]}}, src_step}));

    // R5: a fixed source never moves inside a frame.
    a_r5_fixed_source: assert property (@(posedge clk) disable iff (!rst_n)
        (tr_valid && $past(tr_valid) && src_fixed) |-> (tr_src == $past(tr_src)));

endmodule

bind dma3d_seq dma3d_seq_chk #(.CH_W(CH_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .tr_valid  (tr_valid),
    .tr_src    (tr_src),
    .tr_bytes  (tr_bytes),
    .tr_chan   (tr_chan),
    .done_irq  (done_irq),
    .err_evt   (err_evt),
    .src_fixed (cur.src_fixed),
    .src_step  (cur.src_astride),
    .frame_sync(cur.frame_sync)
);

// File: tb/dma3d_seq_tb_top.sv
// Bench: scoreboard. Driver tasks model each event against a shadow table
// and queue the expected outputs; a monitor compares what the design emits.
module dma3d_seq_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [6:0]  cfg_set = '0;
    logic [2:0]  cfg_word = '0;
    logic [31:0] cfg_wdata = '0;
    logic        evt_valid = 1'b0;
    logic [5:0]  evt_chan = '0;
    logic        tr_valid;
    logic [31:0] tr_src, tr_dst;
    logic [15:0] tr_bytes;
    logic [5:0]  tr_chan;
    logic        done_irq;
    logic [5:0]  done_chan;
    logic        err_evt;
    logic [5:0]  err_chan;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    logic [31:0] sh [128][8];

    int          q_kind[$];
    logic [31:0] q_a[$];
    logic [31:0] q_b[$];
    int          q_c[$];
    string       q_req[$];

    dma3d_seq dut_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_set(cfg_set), .cfg_word(cfg_word), .cfg_wdata(cfg_wdata),
        .evt_valid(evt_valid), .evt_chan(evt_chan),
        .tr_valid(tr_valid), .tr_src(tr_src), .tr_dst(tr_dst), .tr_bytes(tr_bytes), .tr_chan(tr_chan),
        .done_irq(done_irq), .done_chan(done_chan), .err_evt(err_evt), .err_chan(err_chan)
    );

    initial forever #5 clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic push(input int kind, input logic [31:0] a, input logic [31:0] b,
                        input int c, input string req);
        q_kind.push_back(kind); q_a.push_back(a); q_b.push_back(b);
        q_c.push_back(c); q_req.push_back(req);
    endtask

    function automatic logic [31:0] sx(input logic [15:0] v);
        return {{16{v[15]}}, v};
    endfunction

    // R2: word write through the configuration port, mirrored in the shadow.
    task automatic wr(input int s, input int w, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_set = 7'(s); cfg_word = 3'(w); cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        sh[s][w] = d;
    endtask

    task automatic wr_set(input int s, input logic [31:0] opt, input logic [31:0] src,
                          input logic [31:0] dst, input logic [15:0] bytes,
                          input logic [15:0] arrays, input logic [15:0] frames,
                          input logic [15:0] link, input logic [15:0] sa,
                          input logic [15:0] da, input logic [15:0] sf,
                          input logic [15:0] df);
        wr(s, 0, opt); wr(s, 1, src); wr(s, 2, dst);
        wr(s, 3, {arrays, bytes}); wr(s, 4, {link, frames});
        wr(s, 5, {da, sa}); wr(s, 6, {df, sf}); wr(s, 7, {16'd0, arrays});
    endtask

    // Reference model of one event (and any events it chains), from R3-R11.
    task automatic model_evt(input int ch, input string req);
        int c = ch;
        bit go = 1'b1;
        while (go) begin
            logic [31:0] opt, s, d, s0, d0;
            logic [15:0] bytes, arrays, frames, link, n;
            bit fin;
            go = 1'b0;
            opt = sh[c][0]; s0 = sh[c][1]; d0 = sh[c][2];
            bytes = sh[c][3][15:0]; arrays = sh[c][3][31:16];
            frames = sh[c][4][15:0]; link = sh[c][4][31:16];
            if (frames == 0 || arrays == 0) begin
                push(2, 0, 0, c, {req, "/R8"});
                break;
            end
            n = opt[0] ? arrays : 16'd1;
            s = s0; d = d0;
            for (int k = 0; k < int'(n); k++) begin
                push(0, s, d, c * 65536 + int'(bytes), req);
                if (!opt[1]) s = s + sx(sh[c][5][15:0]);
                if (!opt[2]) d = d + sx(sh[c][5][31:16]);
            end
            fin = 1'b0;
            if (!opt[0] && arrays > 1) begin
                if (!opt[1]) s0 = s0 + sx(sh[c][5][15:0]);
                if (!opt[2]) d0 = d0 + sx(sh[c][5][31:16]);
                arrays = arrays - 1;
            end else begin
                if (!opt[1]) s0 = s0 + sx(sh[c][6][15:0]);
                if (!opt[2]) d0 = d0 + sx(sh[c][6][31:16]);
                if (!opt[0]) arrays = sh[c][7][15:0];
                frames = frames - 1;
                fin = (frames == 0);
            end
            if (fin) begin
                if (opt[3]) push(1, 0, 0, c, {req, "/R9"});
                if (link != 16'hFFFF) begin
                    for (int w = 0; w < 8; w++) sh[c][w] = sh[link[6:0]][w];
                end else begin
                    for (int w = 0; w < 8; w++) sh[c][w] = '0;
                end
                if (opt[4]) begin c = int'(opt[13:8]); go = 1'b1; end
            end else begin
                sh[c][1] = s0; sh[c][2] = d0;
                sh[c][3] = {arrays, bytes}; sh[c][4] = {link, frames};
                if (opt[5]) begin c = int'(opt[13:8]); go = 1'b1; end
            end
        end
    endtask

    task automatic fire(input int ch);
        @(negedge clk);
        evt_valid = 1'b1; evt_chan = 6'(ch);
        @(negedge clk);
        evt_valid = 1'b0;
    endtask

    task automatic drain();
        for (int i = 0; i < 2000 && q_kind.size() > 0; i++) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    task automatic event_and_wait(input int ch, input string req);
        model_evt(ch, req);
        fire(ch);
        drain();
    endtask

    // Monitor: compares every observed output against the queue head.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (tr_valid || done_irq || err_evt) begin
                int kind;
                kind = tr_valid ? 0 : (done_irq ? 1 : 2);
                if (q_kind.size() == 0) begin
                    check(1'b0, "R12", "unexpected output kind", kind, 99);
                end else begin
                    int ek, ec;
                    logic [31:0] ea, eb;
                    string r;
                    ek = q_kind.pop_front(); ea = q_a.pop_front(); eb = q_b.pop_front();
                    ec = q_c.pop_front(); r = q_req.pop_front();
                    check(kind == ek, r, "output kind", kind, ek);
                    if (kind == ek && kind == 0) begin
                        check(tr_src == ea, r, "tr_src", tr_src, ea);
                        check(tr_dst == eb, r, "tr_dst", tr_dst, eb);
                        check(int'(tr_chan) * 65536 + int'(tr_bytes) == ec, r, "chan/bytes",
                              int'(tr_chan) * 65536 + int'(tr_bytes), ec);
                    end else if (kind == ek && kind == 1) begin
                        check(int'(done_chan) == ec, r, "done_chan", done_chan, ec);
                    end else if (kind == ek) begin
                        check(int'(err_chan) == ec, r, "err_chan", err_chan, ec);
                    end
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            total++; bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int s = 0; s < 128; s++) for (int w = 0; w < 8; w++) sh[s][w] = '0;
        repeat (3) @(negedge clk);
        // R1: quiet outputs in and just after reset
        check(tr_valid == 1'b0, "R1", "tr_valid in reset", tr_valid, 0);
        check(done_irq == 1'b0, "R1", "done_irq in reset", done_irq, 0);
        check(err_evt == 1'b0, "R1", "err_evt in reset", err_evt, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(tr_valid == 1'b0, "R1", "tr_valid after reset", tr_valid, 0);

        // R1 R8: an untouched descriptor is empty and rejects its event
        event_and_wait(40, "R1");

        // R2 R3 R5 R9: array-per-event, fixed destination, completion pulse
        wr_set(2, 32'h0000_000C, 32'h1000, 32'h8000, 16'd4, 16'd3, 16'd2, 16'hFFFF,
               16'd16, 16'd8, 16'd100, 16'd0);
        for (int e = 0; e < 6; e++) event_and_wait(2, "R3");
        // R7: no link leaves the set empty, so the next event is rejected
        event_and_wait(2, "R7");

        // R4 R6: frame-per-event with negative stride, refilled from set 70
        wr_set(70, 32'h0000_0000, 32'h5000, 32'h6000, 16'd2, 16'd2, 16'd1, 16'hFFFF,
               16'd4, 16'd4, 16'd0, 16'd0);
        wr_set(5, 32'h0000_0009, 32'h2000, 32'h3000, 16'd8, 16'd3, 16'd2, 16'd70,
               16'd8, 16'hFFF8, 16'h0040, 16'h0100);
        event_and_wait(5, "R4");
        event_and_wait(5, "R4");
        event_and_wait(5, "R6");
        event_and_wait(5, "R6");
        event_and_wait(5, "R7");

        // R10: completion of channel 7 posts an event to channel 9
        wr_set(9, 32'h0000_0008, 32'h9000, 32'h9100, 16'd3, 16'd1, 16'd1, 16'hFFFF,
               16'd0, 16'd0, 16'd0, 16'd0);
        wr_set(7, 32'h0000_0919, 32'h7000, 32'h7100, 16'd1, 16'd2, 16'd1, 16'hFFFF,
               16'd2, 16'd2, 16'd0, 16'd0);
        event_and_wait(7, "R10");

        // R11: self-chaining after each non-final event runs the whole block
        wr_set(10, 32'h0000_0A28, 32'hA000, 32'hB000, 16'd5, 16'd2, 16'd2, 16'hFFFF,
               16'd32, 16'd32, 16'h0200, 16'h0400);
        event_and_wait(10, "R11");

        // R12: three events while busy; 20 first, then 13 before 14; 13/14 no pulse (R9)
        wr_set(20, 32'h0000_0001, 32'hC000, 32'hD000, 16'd6, 16'd4, 16'd1, 16'hFFFF,
               16'd16, 16'd16, 16'd0, 16'd0);
        wr_set(13, 32'h0000_0000, 32'h1300, 32'h2300, 16'd1, 16'd1, 16'd1, 16'hFFFF,
               16'd0, 16'd0, 16'd0, 16'd0);
        wr_set(14, 32'h0000_0000, 32'h1400, 32'h2400, 16'd1, 16'd1, 16'd1, 16'hFFFF,
               16'd0, 16'd0, 16'd0, 16'd0);
        model_evt(20, "R12");
        model_evt(13, "R12");
        model_evt(14, "R12");
        @(negedge clk);
        evt_valid = 1'b1; evt_chan = 6'd20;
        @(negedge clk);
        evt_chan = 6'd14;
        @(negedge clk);
        evt_chan = 6'd13;
        @(negedge clk);
        evt_valid = 1'b0;
        drain();

        // R12: nothing expected was lost
        check(q_kind.size() == 0, "R12", "items left in scoreboard", q_kind.size(), 0);

        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule